// File: doc/BRIEF.md
# Runtime-Bounded Tiled Matrix-Multiply Sequencer

This block computes one integer matrix-product tile, C += A x B. The three tile dimensions are chosen at run time, not fixed in hardware. Before a run, a single configuration word is handed over on a valid/ready handshake. The word carries three loop bounds and a clear flag. The sequencer then walks nested loops whose body is one fixed atomic step. The step multiplies a two-row slice of A by an eight-by-eight block of B and adds the result into a two-by-eight block of C. A small job therefore costs only the steps it needs, and it is never padded out to the largest tile.

Operands sit in three local buffers outside the block, each with a one-cycle registered read. The sequencer drives word addresses into the A and B buffers. It reads a C row, adds the new products to it, and writes the updated row back through a read-modify-write port. A busy flag covers the run. A one-cycle done pulse marks the point where the final C write has been committed.

Top module: `mmt_tile_seq`

## Requirements
- R1: `cfg_ready` is high only while the unit is idle. It is low while `busy` is high and during the done cycle. A configuration is taken only on a cycle where `cfg_valid` and `cfg_ready` are both high. If `cfg_valid` is held high during a run, no second run starts.
- R2: The configuration word packs three bounds from the least significant end: bound_i in bits [4:0], bound_k in bits [7:5] and bound_j in bits [10:8]. Bit 11 is the clear flag. The loops nest with i outermost, then j, with k innermost. Each atomic step writes C row 2i and then C row 2i+1, so a run makes 2·bi·bj·bk writes.
- R3: The buffer layouts are fixed, and all elements are signed 8-bit values.
  - A word at address row·4+kb holds A[row][8kb+e] in bits [8e+7:8e].
  - B word at address row·4+jb holds B[row][8jb+e] in the same element positions.
  - C word at address row·4+jb holds the signed 32-bit C[row][8jb+l] in bits [32l+31:32l].
- R4: A C row written for loop indices (i, j, k) and row r equals its previous value plus the sum over e = 0..7 of A[2i+r][8k+e]·B[8k+e][8j+l]. The sum wraps at 32 bits.
- R5: When the clear flag is set, the step with k = 0 uses zero in place of the stored C row. The tile's region of C is therefore overwritten with the fresh product.
- R6: When the clear flag is clear, the run accumulates onto the C contents that were there before it started.
- R7: A bound of zero in any field gives a done pulse in the cycle right after acceptance. Busy never rises, and no C write is made.
- R8: Each atomic step takes 20 cycles, 10 per C row. The first C write falls in the 10th cycle after the acceptance edge. Busy is high for 20·bi·bj·bk cycles. Done is high for exactly one cycle, the one right after the last C write.
- R9: A bound above its largest value is saturated to it: bound_i to 16, bound_k and bound_j to 4.
- R10: Each run uses only the bounds of its own configuration word, so successive runs may use different tile shapes.
- R11: After reset, `cfg_ready` is high and `busy`, `done` and `c_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Unit idle, configuration can be taken |
| cfg_data | input | 12 | Bounds and clear flag (layout in R2) |
| a_addr | output | 7 | A buffer word address |
| a_rdata | input | 64 | A buffer word, one cycle after address |
| b_addr | output | 7 | B buffer word address |
| b_rdata | input | 64 | B buffer word, one cycle after address |
| c_addr | output | 7 | C buffer word address, for both read and write |
| c_rdata | input | 256 | C buffer word, one cycle after address |
| c_we | output | 1 | C write strobe |
| c_wdata | output | 256 | Updated C row |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every result is due at a fixed count of cycles from the acceptance edge. C writes fall on cycles 10, 20, 30 and so on, the done pulse falls on cycle 20·bi·bj·bk+1, and `cfg_ready` returns one cycle after that. For a zero bound, done falls on cycle 1. The driver counts falling edges from the acceptance edge and samples busy, done and ready only at those computed counts. A monitor compares each C write, on the falling edge where the strobe is high, with the next entry in a queue of expected writes. The driver builds that queue from a column-by-column product of the bench's own buffer images, in the loop order of R2.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  parameter int ELEM_W    = 8;
  parameter int ACC_W     = 32;
  parameter int LANES     = 8;
  parameter int ATOM_ROWS = 2;
  parameter int MAX_BI    = 16;
  parameter int MAX_BK    = 4;
  parameter int MAX_BJ    = 4;

  localparam int BI_W     = $clog2(MAX_BI + 1);
  localparam int BK_W     = $clog2(MAX_BK + 1);
  localparam int BJ_W     = $clog2(MAX_BJ + 1);
  localparam int R_W      = (ATOM_ROWS > 1) ? $clog2(ATOM_ROWS) : 1;
  localparam int LANE_W   = $clog2(LANES);
  localparam int ROW_W    = $clog2(ATOM_ROWS * MAX_BI);
  localparam int BROW_W   = $clog2(LANES * MAX_BK);
  localparam int KB_W     = $clog2(MAX_BK);
  localparam int JB_W     = $clog2(MAX_BJ);
  localparam int AADDR_W  = ROW_W + KB_W;
  localparam int BADDR_W  = BROW_W + JB_W;
  localparam int CADDR_W  = ROW_W + JB_W;
  localparam int A_WORD_W = LANES * ELEM_W;
  localparam int B_WORD_W = LANES * ELEM_W;
  localparam int C_WORD_W = LANES * ACC_W;
  localparam int WR_PH    = LANES + 1;
  localparam int PH_W     = $clog2(WR_PH + 1);

  typedef struct packed {
    logic            clear;
    logic [BJ_W-1:0] bj;
    logic [BK_W-1:0] bk;
    logic [BI_W-1:0] bi;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // Saturating bound limit.
  function automatic int unsigned sat_bound(int unsigned v, int unsigned m);
    return (v > m) ? m : v;
  endfunction

  // One lane of multiply-accumulate with wrap at ACC_W.
  function automatic logic signed [ACC_W-1:0] mac_lane(
      logic signed [ACC_W-1:0]  acc,
      logic signed [ELEM_W-1:0] a,
      logic signed [ELEM_W-1:0] b);
    logic signed [2*ELEM_W-1:0] p;
    p = a * b;
    return acc + ACC_W'(p);
  endfunction

  function automatic logic [ROW_W-1:0] tile_row(int unsigned i, int unsigned r);
    return ROW_W'(i * ATOM_ROWS + r);
  endfunction

  function automatic logic [AADDR_W-1:0] a_word(int unsigned row, int unsigned kb);
    return AADDR_W'(row * MAX_BK + kb);
  endfunction

  function automatic logic [BADDR_W-1:0] b_word(int unsigned kb, int unsigned kk, int unsigned jb);
    return BADDR_W'((kb * LANES + kk) * MAX_BJ + jb);
  endfunction

  function automatic logic [CADDR_W-1:0] c_word(int unsigned row, int unsigned jb);
    return CADDR_W'(row * MAX_BJ + jb);
  endfunction
endpackage

// File: rtl/mmt_loop_ctrl.sv
module mmt_loop_ctrl
  import mmt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BI_W-1:0] bnd_i,
  input  logic [BK_W-1:0] bnd_k,
  input  logic [BJ_W-1:0] bnd_j,
  output logic            active,
  output logic [PH_W-1:0] ph,
  output logic [BI_W-1:0] idx_i,
  output logic [BJ_W-1:0] idx_j,
  output logic [BK_W-1:0] idx_k,
  output logic [R_W-1:0]  idx_r,
  output logic            wr_phase,
  output logic            step_last
);
  logic ph_end, r_end, k_end, j_end, i_end;

  assign ph_end    = (ph == PH_W'(WR_PH));
  assign r_end     = (idx_r == R_W'(ATOM_ROWS - 1));
  assign k_end     = (idx_k == bnd_k - BK_W'(1));
  assign j_end     = (idx_j == bnd_j - BJ_W'(1));
  assign i_end     = (idx_i == bnd_i - BI_W'(1));
  assign wr_phase  = active & ph_end;
  assign step_last = wr_phase & r_end & k_end & j_end & i_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph     <= '0;
      idx_i  <= '0;
      idx_j  <= '0;
      idx_k  <= '0;
      idx_r  <= '0;
    end else if (start) begin
      active <= 1'b1;
      ph     <= '0;
      idx_i  <= '0;
      idx_j  <= '0;
      idx_k  <= '0;
      idx_r  <= '0;
    end else if (active) begin
      if (!ph_end) begin
        ph <= ph + PH_W'(1);
      end else begin
        ph <= '0;
        if (!r_end) begin
          idx_r <= idx_r + R_W'(1);
        end else begin
          idx_r <= '0;
          if (!k_end) begin
            idx_k <= idx_k + BK_W'(1);
          end else begin
            idx_k <= '0;
            if (!j_end) begin
              idx_j <= idx_j + BJ_W'(1);
            end else begin
              idx_j <= '0;
              if (!i_end) idx_i <= idx_i + BI_W'(1);
              else begin
                idx_i  <= '0;
                active <= 1'b0;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/mmt_row_mac.sv
module mmt_row_mac
  import mmt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PH_W-1:0]     ph,
  input  logic                zero_base,
  input  logic [A_WORD_W-1:0] a_rdata,
  input  logic [B_WORD_W-1:0] b_rdata,
  input  logic [C_WORD_W-1:0] c_rdata,
  output logic [C_WORD_W-1:0] c_wdata
);
  logic [ELEM_W-1:0] a_row [LANES];
  logic              first_ph, mac_ph;
  logic [LANE_W-1:0] a_sel;

  assign first_ph = (ph == PH_W'(1));
  assign mac_ph   = (ph > PH_W'(1)) && (ph <= PH_W'(LANES));
  assign a_sel    = LANE_W'(ph - PH_W'(1));

  for (genvar e = 0; e < LANES; e++) begin : g_arow
    always_ff @(posedge clk) begin
      if (!rst_n)        a_row[e] <= '0;
      else if (first_ph) a_row[e] <= a_rdata[e*ELEM_W +: ELEM_W];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] base;
    assign base = zero_base ? '0 : c_rdata[l*ACC_W +: ACC_W];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc <= '0;
      end else if (first_ph) begin
        acc <= mac_lane(base, a_rdata[0 +: ELEM_W], b_rdata[l*ELEM_W +: ELEM_W]);
      end else if (mac_ph) begin
        acc <= mac_lane(acc, a_row[a_sel], b_rdata[l*ELEM_W +: ELEM_W]);
      end
    end
    assign c_wdata[l*ACC_W +: ACC_W] = acc;
  end
endmodule

// File: rtl/mmt_tile_seq.sv
module mmt_tile_seq
  import mmt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_valid,
  output logic                cfg_ready,
  input  logic [CFG_W-1:0]    cfg_data,
  output logic [AADDR_W-1:0]  a_addr,
  input  logic [A_WORD_W-1:0] a_rdata,
  output logic [BADDR_W-1:0]  b_addr,
  input  logic [B_WORD_W-1:0] b_rdata,
  output logic [CADDR_W-1:0]  c_addr,
  input  logic [C_WORD_W-1:0] c_rdata,
  output logic                c_we,
  output logic [C_WORD_W-1:0] c_wdata,
  output logic                busy,
  output logic                done
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;

  st_e             state;
  cfg_t            cfg_in;
  logic [BI_W-1:0] bi_q;
  logic [BK_W-1:0] bk_q;
  logic [BJ_W-1:0] bj_q;
  logic            clr_q;

  // Named events for the checker.
  logic            accept, run_empty, start_run, step_last, wr_phase, active;

  logic [PH_W-1:0] ph;
  logic [BI_W-1:0] idx_i;
  logic [BJ_W-1:0] idx_j;
  logic [BK_W-1:0] idx_k;
  logic [R_W-1:0]  idx_r;
  logic [ROW_W-1:0] row;

  assign cfg_in    = cfg_t'(cfg_data);
  assign cfg_ready = (state == ST_IDLE);
  assign accept    = cfg_valid & cfg_ready;
  assign run_empty = (cfg_in.bi == '0) | (cfg_in.bk == '0) | (cfg_in.bj == '0);
  assign start_run = accept & ~run_empty;
  assign busy      = (state == ST_RUN);
  assign done      = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      bi_q  <= '0;
      bk_q  <= '0;
      bj_q  <= '0;
      clr_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          bi_q  <= BI_W'(sat_bound(32'(cfg_in.bi), MAX_BI));
          bk_q  <= BK_W'(sat_bound(32'(cfg_in.bk), MAX_BK));
          bj_q  <= BJ_W'(sat_bound(32'(cfg_in.bj), MAX_BJ));
          clr_q <= cfg_in.clear;
          state <= run_empty ? ST_FIN : ST_RUN;
        end
        ST_RUN:  if (step_last) state <= ST_FIN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  mmt_loop_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_run),
    .bnd_i    (bi_q),
    .bnd_k    (bk_q),
    .bnd_j    (bj_q),
    .active   (active),
    .ph       (ph),
    .idx_i    (idx_i),
    .idx_j    (idx_j),
    .idx_k    (idx_k),
    .idx_r    (idx_r),
    .wr_phase (wr_phase),
    .step_last(step_last)
  );

  assign row    = tile_row(32'(idx_i), 32'(idx_r));
  assign a_addr = a_word(32'(row), 32'(idx_k));
  assign b_addr = b_word(32'(idx_k), 32'(LANE_W'(ph)), 32'(idx_j));
  assign c_addr = c_word(32'(row), 32'(idx_j));
  assign c_we   = wr_phase;

  mmt_row_mac u_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph       (ph),
    .zero_base(clr_q & (idx_k == '0)),
    .a_rdata  (a_rdata),
    .b_rdata  (b_rdata),
    .c_rdata  (c_rdata),
    .c_wdata  (c_wdata)
  );
endmodule

// File: rtl/mmt_tile_seq_chk.sv
module mmt_tile_seq_chk
  import mmt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_data,
  input logic             cfg_ready,
  input logic             accept,
  input logic             busy,
  input logic             done,
  input logic             c_we,
  input logic [BI_W-1:0]  bi_q,
  input logic [BK_W-1:0]  bk_q,
  input logic [BJ_W-1:0]  bj_q
);
  cfg_t cfg_v;
  int   wr_cnt;
  assign cfg_v = cfg_t'(cfg_data);

  always_ff @(posedge clk) begin
    if (!rst_n)      wr_cnt <= 0;
    else if (accept) wr_cnt <= 0;
    else if (c_we)   wr_cnt <= wr_cnt + 1;
  end

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || done) |-> !cfg_ready);

  assert_write_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_cnt == ATOM_ROWS * int'(bi_q) * int'(bj_q) * int'(bk_q)));

  assert_zero_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cfg_v.bi == '0 || cfg_v.bk == '0 || cfg_v.bj == '0)) |=> (done && !busy));

  assert_we_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    c_we |-> busy);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_bounds_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bi_q <= BI_W'(MAX_BI) && bk_q <= BK_W'(MAX_BK) && bj_q <= BJ_W'(MAX_BJ)));
endmodule

bind mmt_tile_seq mmt_tile_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_data (cfg_data),
  .cfg_ready(cfg_ready),
  .accept   (accept),
  .busy     (busy),
  .done     (done),
  .c_we     (c_we),
  .bi_q     (bi_q),
  .bk_q     (bk_q),
  .bj_q     (bj_q)
);

// File: tb/mmt_tile_seq_bench.sv
`timescale 1ns/1ps
module mmt_tile_seq_bench;
  import mmt_pkg::*;

  localparam int DEPTH = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0;
  logic cfg_ready;
  logic [CFG_W-1:0] cfg_data = '0;
  logic [AADDR_W-1:0] a_addr;
  logic [BADDR_W-1:0] b_addr;
  logic [CADDR_W-1:0] c_addr;
  logic [A_WORD_W-1:0] a_rdata;
  logic [B_WORD_W-1:0] b_rdata;
  logic [C_WORD_W-1:0] c_rdata, c_wdata;
  logic c_we, busy, done;

  logic [A_WORD_W-1:0] amem [DEPTH];
  logic [B_WORD_W-1:0] bmem [DEPTH];
  logic [C_WORD_W-1:0] cmem [DEPTH];
  logic [C_WORD_W-1:0] gm   [DEPTH];

  logic [CADDR_W-1:0]  exp_addr_q [$];
  logic [C_WORD_W-1:0] exp_data_q [$];

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  mmt_tile_seq u_mmt_tile_seq (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_data(cfg_data), .a_addr(a_addr), .a_rdata(a_rdata), .b_addr(b_addr),
    .b_rdata(b_rdata), .c_addr(c_addr), .c_rdata(c_rdata), .c_we(c_we),
    .c_wdata(c_wdata), .busy(busy), .done(done)
  );

  // Buffer models: one-cycle registered reads, C written on strobe.
  always @(posedge clk) begin
    a_rdata <= amem[a_addr];
    b_rdata <= bmem[b_addr];
    c_rdata <= cmem[c_addr];
    if (c_we) cmem[c_addr] <= c_wdata;
  end

  task automatic check(bit ok, string req, string what, logic [C_WORD_W-1:0] act,
                       logic [C_WORD_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int elem_a(int row, int col);
    logic signed [ELEM_W-1:0] v;
    v = amem[row * MAX_BK + col / LANES][(col % LANES) * ELEM_W +: ELEM_W];
    return int'(v);
  endfunction

  function automatic int elem_b(int row, int col);
    logic signed [ELEM_W-1:0] v;
    v = bmem[row * MAX_BJ + col / LANES][(col % LANES) * ELEM_W +: ELEM_W];
    return int'(v);
  endfunction

  task automatic fill(int seed);
    for (int a = 0; a < DEPTH; a++) begin
      for (int e = 0; e < LANES; e++) begin
        amem[a][e*ELEM_W +: ELEM_W] = ELEM_W'((a * 29 + e * 13 + seed * 7) % 251 - 125);
        bmem[a][e*ELEM_W +: ELEM_W] = ELEM_W'((a * 17 + e * 41 + seed * 3) % 241 - 120);
        cmem[a][e*ACC_W +: ACC_W]   = ACC_W'((a * 1001 + e * 17 - 3000) * seed);
      end
      gm[a] = cmem[a];
    end
  endtask

  // Driver: builds expected writes (R2..R6), hands over the word, times the run (R1, R8).
  task automatic run_tile(int bi, int bk, int bj, bit clr, bit poke, string tag);
    int ei, ek, ej, n, busy_bad;
    logic [C_WORD_W-1:0] w;
    ei = (bi > MAX_BI) ? MAX_BI : bi;   // R9 saturation
    ek = (bk > MAX_BK) ? MAX_BK : bk;
    ej = (bj > MAX_BJ) ? MAX_BJ : bj;
    n  = 20 * ei * ek * ej;
    for (int i = 0; i < ei; i++)
      for (int j = 0; j < ej; j++)
        for (int k = 0; k < ek; k++)
          for (int r = 0; r < 2; r++) begin
            int row;
            row = 2 * i + r;
            w = gm[row * MAX_BJ + j];
            for (int l = 0; l < LANES; l++) begin
              int col, s;
              col = 8 * j + l;
              s = (clr && k == 0) ? 0 : int'($signed(w[l*ACC_W +: ACC_W]));
              for (int t = 0; t < 8; t++) s += elem_a(row, 8 * k + t) * elem_b(8 * k + t, col);
              w[l*ACC_W +: ACC_W] = ACC_W'(s);
            end
            gm[row * MAX_BJ + j] = w;
            exp_addr_q.push_back(CADDR_W'(row * MAX_BJ + j));
            exp_data_q.push_back(w);
          end
    @(negedge clk);
    check(cfg_ready, "R1", {tag, " ready when idle"}, C_WORD_W'(cfg_ready), 1);
    cfg_data  = CFG_W'({clr, 3'(bj), 3'(bk), 5'(bi)});
    cfg_valid = 1'b1;
    @(posedge clk);
    #1;
    if (poke) cfg_data = CFG_W'({1'b1, 3'd1, 3'd1, 5'd1});
    else cfg_valid = 1'b0;
    busy_bad = 0;
    for (int t = 1; t <= n + 2; t++) begin
      @(negedge clk);
      if (t <= n && (!busy || done || cfg_ready)) busy_bad++;
      if (t == n) cfg_valid = 1'b0;
      if (t == n + 1) begin
        check(done && !busy, "R8", {tag, " done in cycle after last write"},
              C_WORD_W'({busy, done}), 1);
        check(!cfg_ready, "R1", {tag, " ready low in done cycle"}, C_WORD_W'(cfg_ready), 0);
      end
      if (t == n + 2)
        check(!done && cfg_ready, "R8", {tag, " done lasts one cycle"},
              C_WORD_W'({done, cfg_ready}), 1);
    end
    cfg_valid = 1'b0;
    check(busy_bad == 0, "R8", {tag, " busy for 20*bi*bj*bk cycles"}, C_WORD_W'(busy_bad), 0);
    repeat (4) @(negedge clk);
    check(!busy && !done, "R1", {tag, " no extra run"}, C_WORD_W'({busy, done}), 0);
    check(exp_addr_q.size() == 0, "R2", {tag, " all expected writes seen"},
          C_WORD_W'(exp_addr_q.size()), 0);
    begin
      int bad;
      bad = 0;
      for (int a = 0; a < DEPTH; a++) if (cmem[a] !== gm[a]) bad++;
      check(bad == 0, "R4", {tag, " C image after run"}, C_WORD_W'(bad), 0);
    end
  endtask

  // Monitor: compares each C write with the scoreboard (R2, R3, R4).
  always @(negedge clk) begin
    if (rst_n && c_we) begin
      if (exp_addr_q.size() == 0) begin
        check(1'b0, "R2", "unexpected C write", C_WORD_W'(c_addr), 0);
      end else begin
        logic [CADDR_W-1:0]  ea;
        logic [C_WORD_W-1:0] ed;
        ea = exp_addr_q.pop_front();
        ed = exp_data_q.pop_front();
        check(c_addr == ea, "R2", "C write address", C_WORD_W'(c_addr), C_WORD_W'(ea));
        check(c_wdata == ed, "R4", "C write data", c_wdata, ed);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    fill(1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(cfg_ready && !busy && !done && !c_we, "R11", "reset state",
          C_WORD_W'({cfg_ready, busy, done, c_we}), C_WORD_W'(4'b1000));
    run_tile(1, 1, 1, 1'b1, 1'b0, "R5 smallest tile with clear");
    run_tile(2, 3, 1, 1'b0, 1'b0, "R6 accumulate, R10 new shape");
    run_tile(16, 4, 4, 1'b1, 1'b0, "R3 largest tile");
    fill(5);
    run_tile(3, 2, 4, 1'b0, 1'b1, "R1 valid held during run");
    run_tile(0, 2, 2, 1'b1, 1'b0, "R7 zero i bound");
    run_tile(2, 0, 3, 1'b0, 1'b0, "R7 zero k bound");
    run_tile(1, 1, 0, 1'b1, 1'b0, "R7 zero j bound");
    run_tile(20, 1, 6, 1'b0, 1'b0, "R9 bounds saturate");
    run_tile(1, 4, 2, 1'b1, 1'b0, "R10 reshape after saturation");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule